// File: doc/BRIEF.md
# Rotating-Parity Small-Write Engine

This block carries out one block-sized write into a five-disk array whose parity block moves from disk to disk row by row. A host hands it a logical block number and then streams the new block as words. The engine works out which stripe row the block lives in, which disk holds it and which disk holds that row's parity. It then updates the array through a single shared disk command port. It reads the old data block and the old parity block, writes the new data block, and writes a parity block rebuilt from those three blocks alone. The other three data blocks of the row are never read.

Both incoming blocks are folded word by word into a local accumulator: first new XOR old data, then that result XOR old parity. The accumulator is therefore the new parity by the time both reads end. The host sees a single busy indication for the whole sequence. While it is high, a further request is refused.

Top module: `parity_rmw_engine`

## Requirements
- R1: The stripe row sent with every command equals the logical block number shifted right by two bits. The low two bits select the block's slot within the row.
- R2: The parity disk of row r is 4 - (r mod 5). Row 0 uses disk 4, row 4 uses disk 0, and the pattern repeats every five rows. Disk numbers stay in the range 0..4.
- R3: Slot s goes to disk s when s is below the parity disk, and to disk s+1 otherwise.
- R4: Each request issues exactly four commands in this order: read of the data disk, read of the parity disk, write of the data disk, write of the parity disk. cmdWrite is 1 for a write and 0 for a read.
- R5: After completion, word w of the parity block equals old parity XOR old data XOR new data at word w. This leaves it equal to the XOR of the row's four data blocks.
- R6: The data write carries the new words in the order the host supplied them, and they land at block offsets 0 upward.
- R7: No write command is raised before 2×BLOCK_WORDS read words, one full block from each read, have been received for the current request.
- R8: busy rises on the cycle after a request is accepted and stays high until the acknowledge of the parity write has been taken. reqReady is low whenever busy is high, so a request offered during that time is not taken.
- R9: While cmdValid is high and cmdReady is low, cmdValid stays high and cmdDisk, cmdRow and cmdWrite hold their values.
- R10: hostReady is high only in the load phase that follows acceptance, and never together with cmdValid or wrValid. Exactly BLOCK_WORDS words are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host offers a write request |
| reqReady | output | 1 | Engine idle, request taken when both high |
| reqLba | input | LBA_W | Logical block number of the request |
| hostValid | input | 1 | New-data word valid |
| hostReady | output | 1 | Engine takes a new-data word |
| hostData | input | WORD_W | New-data word |
| busy | output | 1 | Request in progress |
| cmdValid | output | 1 | Disk command valid |
| cmdReady | input | 1 | Disk command accepted |
| cmdWrite | output | 1 | 1 = block write, 0 = block read |
| cmdDisk | output | 3 | Target disk 0..4 |
| cmdRow | output | LBA_W-2 | Stripe row on the target disk |
| rdValid | input | 1 | Read word from disk valid |
| rdData | input | WORD_W | Read word from disk |
| wrValid | output | 1 | Write word valid |
| wrReady | input | 1 | Disk takes the write word |
| wrData | output | WORD_W | Write word to disk |
| wrAck | input | 1 | One-cycle pulse: block write committed |

## Verification
The hardest case to reach from the ports is a command stalled while the disk side keeps cmdReady low, combined with read words that arrive with gaps and write slots that open only every other cycle. Only that mix checks that the shared word counter and the command fields stay correct under backpressure. The bench's disk model holds cmdReady off for a programmable number of cycles and can alternate its read and write handshakes. It logs every accepted command together with the number of read words delivered so far. Another hard case is a request raised while the engine is busy. The bench keeps a second request asserted through the whole sequence and confirms that exactly four commands, all for the first row, are issued.

// File: rtl/prw_pkg.sv
package prw_pkg;
  localparam int DISK_COUNT = 5;
  localparam int SLOTS_PER_ROW = DISK_COUNT - 1;

  typedef struct packed {
    logic latchReq;
    logic loadNew;
    logic accInit;
    logic accFold;
    logic selParity;
    logic cntInc;
  } prwStrobe_t;
endpackage

// File: rtl/prw_datapath.sv
module prw_datapath
  import prw_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 8,
  parameter int LBA_W       = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  prwStrobe_t          strb,
  input  logic [LBA_W-1:0]    reqLba,
  input  logic [WORD_W-1:0]   hostData,
  input  logic [WORD_W-1:0]   rdData,
  output logic                cntLast,
  output logic [2:0]          cmdDisk,
  output logic [LBA_W-3:0]    cmdRow,
  output logic [WORD_W-1:0]   wrData
);
  localparam int IDX_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
  localparam int ROW_W = LBA_W - 2;

  logic [IDX_W-1:0]  cnt;
  logic [ROW_W-1:0]  rowQ;
  logic [1:0]        slotQ;
  logic [WORD_W-1:0] newBuf [BLOCK_WORDS];
  logic [WORD_W-1:0] accBuf [BLOCK_WORDS];
  logic [2:0]        rowMod;
  logic [2:0]        parityDisk;
  logic [2:0]        dataDisk;
  logic [2:0]        slotWide;

  assign cntLast = (cnt == IDX_W'(BLOCK_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      rowQ  <= '0;
      slotQ <= '0;
    end else if (strb.latchReq) begin
      rowQ  <= reqLba[LBA_W-1:2];
      slotQ <= reqLba[1:0];
      cnt   <= '0;
    end else if (strb.cntInc) begin
      cnt <= cntLast ? '0 : cnt + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.loadNew) newBuf[cnt] <= hostData;
    if (strb.accInit)      accBuf[cnt] <= newBuf[cnt] ^ rdData;
    else if (strb.accFold) accBuf[cnt] <= accBuf[cnt] ^ rdData;
  end

  // Rotating placement: parity walks down from the last disk, row by row.
  assign rowMod     = 3'(rowQ % ROW_W'(DISK_COUNT));
  assign parityDisk = 3'(DISK_COUNT - 1) - rowMod;
  assign slotWide   = {1'b0, slotQ};
  assign dataDisk   = (slotWide < parityDisk) ? slotWide : slotWide + 3'd1;

  assign cmdDisk = strb.selParity ? parityDisk : dataDisk;
  assign cmdRow  = rowQ;
  assign wrData  = strb.selParity ? accBuf[cnt] : newBuf[cnt];
endmodule

// File: rtl/prw_ctrl.sv
module prw_ctrl
  import prw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hostValid,
  input  logic       cmdReady,
  input  logic       rdValid,
  input  logic       wrReady,
  input  logic       wrAck,
  input  logic       cntLast,
  output prwStrobe_t strb,
  output logic       reqReady,
  output logic       hostReady,
  output logic       cmdValid,
  output logic       cmdWrite,
  output logic       wrValid,
  output logic       busy
);
  typedef enum logic [3:0] {
    IDLE, LOAD,
    RDD_CMD, RDD_DAT, RDP_CMD, RDP_DAT,
    WRD_CMD, WRD_DAT, WRD_ACK,
    WRP_CMD, WRP_DAT, WRP_ACK
  } state_t;

  state_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt       = st;
    strb      = '0;
    reqReady  = 1'b0;
    hostReady = 1'b0;
    cmdValid  = 1'b0;
    cmdWrite  = 1'b0;
    wrValid   = 1'b0;
    unique case (st)
      IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.latchReq = 1'b1;
          nxt = LOAD;
        end
      end
      LOAD: begin
        hostReady = 1'b1;
        if (hostValid) begin
          strb.loadNew = 1'b1;
          strb.cntInc  = 1'b1;
          if (cntLast) nxt = RDD_CMD;
        end
      end
      RDD_CMD: begin
        cmdValid = 1'b1;
        if (cmdReady) nxt = RDD_DAT;
      end
      RDD_DAT: begin
        if (rdValid) begin
          strb.accInit = 1'b1;
          strb.cntInc  = 1'b1;
          if (cntLast) nxt = RDP_CMD;
        end
      end
      RDP_CMD: begin
        strb.selParity = 1'b1;
        cmdValid = 1'b1;
        if (cmdReady) nxt = RDP_DAT;
      end
      RDP_DAT: begin
        strb.selParity = 1'b1;
        if (rdValid) begin
          strb.accFold = 1'b1;
          strb.cntInc  = 1'b1;
          if (cntLast) nxt = WRD_CMD;
        end
      end
      WRD_CMD: begin
        cmdValid = 1'b1;
        cmdWrite = 1'b1;
        if (cmdReady) nxt = WRD_DAT;
      end
      WRD_DAT: begin
        wrValid = 1'b1;
        if (wrReady) begin
          strb.cntInc = 1'b1;
          if (cntLast) nxt = WRD_ACK;
        end
      end
      WRD_ACK: if (wrAck) nxt = WRP_CMD;
      WRP_CMD: begin
        strb.selParity = 1'b1;
        cmdValid = 1'b1;
        cmdWrite = 1'b1;
        if (cmdReady) nxt = WRP_DAT;
      end
      WRP_DAT: begin
        strb.selParity = 1'b1;
        wrValid = 1'b1;
        if (wrReady) begin
          strb.cntInc = 1'b1;
          if (cntLast) nxt = WRP_ACK;
        end
      end
      WRP_ACK: begin
        strb.selParity = 1'b1;
        if (wrAck) nxt = IDLE;
      end
      default: nxt = IDLE;
    endcase
  end

  assign busy = (st != IDLE);
endmodule

// File: rtl/parity_rmw_engine.sv
module parity_rmw_engine
  import prw_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 8,
  parameter int LBA_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [LBA_W-1:0]  reqLba,
  input  logic              hostValid,
  output logic              hostReady,
  input  logic [WORD_W-1:0] hostData,
  output logic              busy,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic              cmdWrite,
  output logic [2:0]        cmdDisk,
  output logic [LBA_W-3:0]  cmdRow,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] rdData,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [WORD_W-1:0] wrData,
  input  logic              wrAck
);
  prwStrobe_t strb;
  logic       cntLast;

  prw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .hostValid(hostValid), .cmdReady(cmdReady),
    .rdValid(rdValid), .wrReady(wrReady), .wrAck(wrAck), .cntLast(cntLast),
    .strb(strb), .reqReady(reqReady), .hostReady(hostReady),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .wrValid(wrValid), .busy(busy)
  );

  prw_datapath #(.WORD_W(WORD_W), .BLOCK_WORDS(BLOCK_WORDS), .LBA_W(LBA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqLba(reqLba),
    .hostData(hostData), .rdData(rdData), .cntLast(cntLast),
    .cmdDisk(cmdDisk), .cmdRow(cmdRow), .wrData(wrData)
  );
endmodule

// File: rtl/prw_checker.sv
module prw_checker #(
  parameter int BLOCK_WORDS = 8,
  parameter int LBA_W       = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             hostReady,
  input logic             busy,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic             cmdWrite,
  input logic [2:0]       cmdDisk,
  input logic [LBA_W-3:0] cmdRow,
  input logic             rdValid,
  input logic             wrValid
);
  logic [31:0] rdWords;

  always_ff @(posedge clk) begin
    if (!rstN)                      rdWords <= '0;
    else if (reqValid && reqReady)  rdWords <= '0;
    else if (rdValid && busy)       rdWords <= rdWords + 32'd1;
  end

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);

  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdDisk) && $stable(cmdRow) && $stable(cmdWrite)));

  assert_disk_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdDisk < 3'd5));

  assert_write_after_reads_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdWrite) |-> (rdWords == 32'(2 * BLOCK_WORDS)));

  assert_load_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> (!cmdValid && !wrValid && busy));
endmodule

bind parity_rmw_engine prw_checker #(.BLOCK_WORDS(BLOCK_WORDS), .LBA_W(LBA_W)) u_prw_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .hostReady(hostReady), .busy(busy), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdWrite(cmdWrite), .cmdDisk(cmdDisk), .cmdRow(cmdRow),
  .rdValid(rdValid), .wrValid(wrValid)
);

// File: tb/parity_rmw_engine_bench.sv
module parity_rmw_engine_bench;
  localparam int NW = 8;
  localparam int NR = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqLba = '0;
  logic        hostValid = 1'b0;
  logic        hostReady;
  logic [31:0] hostData = '0;
  logic        busy;
  logic        cmdValid;
  logic        cmdReady;
  logic        cmdWrite;
  logic [2:0]  cmdDisk;
  logic [13:0] cmdRow;
  logic        rdValid;
  logic [31:0] rdData;
  logic        wrValid;
  logic        wrReady;
  logic [31:0] wrData;
  logic        wrAck;

  always #4 clk = ~clk;

  parity_rmw_engine #(.WORD_W(32), .BLOCK_WORDS(NW), .LBA_W(16)) u_parity_rmw_engine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqLba(reqLba),
    .hostValid(hostValid), .hostReady(hostReady), .hostData(hostData), .busy(busy),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWrite(cmdWrite), .cmdDisk(cmdDisk),
    .cmdRow(cmdRow), .rdValid(rdValid), .rdData(rdData), .wrValid(wrValid),
    .wrReady(wrReady), .wrData(wrData), .wrAck(wrAck)
  );

  // ---------------- disk model ----------------
  logic [31:0] disk [5][NR][NW];
  int          cmdLag = 0;
  bit          gapMode = 1'b0;
  bit          tog;
  int          mode, ptr, mDisk, mRow, waitCnt;
  int          logN, rdTotal, ackN, holdErr;
  bit          logWr [8];
  int          logDisk [8];
  int          logRow [8];
  int          logRdAt [8];
  bit          pValid;
  logic [2:0]  pDisk;
  logic [13:0] pRow;
  logic        pWrite;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NR; r++) begin
        for (int w = 0; w < NW; w++) begin
          automatic int pd = 4 - (r % 5);
          automatic logic [31:0] x = '0;
          for (int s = 0; s < 4; s++) begin
            automatic int dd = (s < pd) ? s : s + 1;
            automatic logic [31:0] v = 32'h5A00_0000 ^ (r << 16) ^ (dd << 8) ^ (w * 32'h0011_0013);
            disk[dd][r][w] <= v;
            x = x ^ v;
          end
          disk[pd][r][w] <= x;
        end
      end
      cmdReady <= 1'b0; rdValid <= 1'b0; rdData <= '0; wrReady <= 1'b0; wrAck <= 1'b0;
      mode <= 0; ptr <= 0; logN <= 0; rdTotal <= 0; ackN <= 0; holdErr <= 0;
      waitCnt <= 0; tog <= 1'b0; pValid <= 1'b0; mDisk <= 0; mRow <= 0;
    end else begin
      tog   <= ~tog;
      wrAck <= 1'b0;
      if (reqValid && reqReady) begin
        logN <= 0; rdTotal <= 0; ackN <= 0;
      end
      if (pValid && (!cmdValid || cmdDisk != pDisk || cmdRow != pRow || cmdWrite != pWrite))
        holdErr <= holdErr + 1;
      pValid <= cmdValid && !cmdReady;
      pDisk <= cmdDisk; pRow <= cmdRow; pWrite <= cmdWrite;
      if (cmdValid && cmdReady) begin
        cmdReady <= 1'b0;
        waitCnt  <= 0;
        if (logN < 8) begin
          logWr[logN] <= cmdWrite; logDisk[logN] <= int'(cmdDisk);
          logRow[logN] <= int'(cmdRow); logRdAt[logN] <= rdTotal;
        end
        logN  <= logN + 1;
        mDisk <= int'(cmdDisk);
        mRow  <= int'(cmdRow) % NR;
        ptr   <= 0;
        mode  <= cmdWrite ? 2 : 1;
      end else if (cmdValid) begin
        if (waitCnt >= cmdLag) cmdReady <= 1'b1;
        waitCnt <= waitCnt + 1;
      end
      rdValid <= 1'b0;
      if (mode == 1 && !(gapMode && tog)) begin
        rdValid <= 1'b1;
        rdData  <= disk[mDisk][mRow][ptr];
        rdTotal <= rdTotal + 1;
        ptr     <= ptr + 1;
        if (ptr == NW - 1) mode <= 0;
      end
      if (mode == 2) begin
        wrReady <= !(gapMode && tog);
        if (wrValid && wrReady) begin
          disk[mDisk][mRow][ptr] <= wrData;
          ptr <= ptr + 1;
          if (ptr == NW - 1) begin
            mode <= 3;
            wrReady <= 1'b0;
          end
        end
      end
      if (mode == 3) begin
        wrAck <= 1'b1;
        ackN  <= ackN + 1;
        mode  <= 0;
      end
    end
  end

  // ---------------- checking ----------------
  int vectors = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(busy == 1'b0, "R8", "busy after reset", int'(busy), 0);
    check(reqReady == 1'b1, "R8", "reqReady after reset", int'(reqReady), 1);
    check(!cmdValid && !wrValid, "R4", "no command after reset", int'(cmdValid), 0);
    check(hostReady == 1'b0, "R10", "hostReady after reset", int'(hostReady), 0);
  endtask

  task automatic do_write(input int lba, input int seed, input int lag, input bit gap, input bit inject);
    logic [31:0] nd [NW];
    int row, slot, pd, dd, cyc, blocked;
    bit rdy;
    row = lba / 4; slot = lba % 4;
    pd = 4 - (row % 5);
    dd = (slot < pd) ? slot : slot + 1;
    for (int w = 0; w < NW; w++) nd[w] = 32'(seed) * 32'h9E37_79B1 ^ (w * 32'h0101_0101);
    cmdLag = lag; gapMode = gap;
    // request
    do begin
      @(negedge clk);
      reqValid = 1'b1; reqLba = 16'(lba);
      rdy = reqReady;
      @(posedge clk);
    end while (!rdy);
    @(negedge clk);
    check(busy == 1'b1, "R8", "busy after accept", int'(busy), 1);
    if (inject) begin
      reqLba = 16'(lba + 4);
    end else begin
      reqValid = 1'b0;
    end
    // new data stream
    for (int w = 0; w < NW; w++) begin
      do begin
        if (w != 0 || rdy) @(negedge clk);
        hostValid = 1'b1; hostData = nd[w];
        rdy = hostReady;
        @(posedge clk);
      end while (!rdy);
    end
    @(negedge clk);
    hostValid = 1'b0;
    check(hostReady == 1'b0, "R10", "hostReady after block", int'(hostReady), 0);
    // wait for completion
    cyc = 0; blocked = 0;
    while (busy && cyc < 2000) begin
      if (reqReady) blocked++;
      @(negedge clk);
      cyc++;
    end
    reqValid = 1'b0;
    check(ackN == 2 && logN == 4, "R8", "busy fell after second ack", ackN * 16 + logN, 2 * 16 + 4);
    check(blocked == 0, "R8", "reqReady while busy", blocked, 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && logN == 4, "R8", "second request ignored", logN, 4);
    // command sequence
    check(logRow[0] == row && logRow[1] == row && logRow[2] == row && logRow[3] == row,
          "R1", "row on commands", logRow[3], row);
    check(logDisk[1] == pd && logDisk[3] == pd, "R2", "parity disk", logDisk[1], pd);
    check(logDisk[0] == dd && logDisk[2] == dd, "R3", "data disk", logDisk[0], dd);
    check(!logWr[0] && !logWr[1] && logWr[2] && logWr[3], "R4", "read,read,write,write",
          {28'd0, logWr[0], logWr[1], logWr[2], logWr[3]}, 4'b0011);
    check(logRdAt[1] == NW && logRdAt[2] == 2 * NW && logRdAt[3] == 2 * NW,
          "R7", "read words before writes", logRdAt[2], 2 * NW);
    check(holdErr == 0, "R9", "command held under stall", holdErr, 0);
    for (int w = 0; w < NW; w++) begin
      logic [31:0] x;
      x = '0;
      check(disk[dd][row][w] == nd[w], "R6", $sformatf("data word %0d lba %0d", w, lba),
            int'(disk[dd][row][w]), int'(nd[w]));
      for (int s = 0; s < 4; s++) x ^= disk[(s < pd) ? s : s + 1][row][w];
      check(disk[pd][row][w] == x, "R5", $sformatf("parity word %0d lba %0d", w, lba),
            int'(disk[pd][row][w]), int'(x));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    do_write(0, 1, 0, 1'b0, 1'b0);
    do_write(7, 2, 3, 1'b1, 1'b0);
    do_write(9, 3, 1, 1'b0, 1'b0);
    do_write(10, 4, 2, 1'b1, 1'b0);
    do_write(16, 5, 0, 1'b1, 1'b0);
    do_write(19, 6, 3, 1'b0, 1'b0);
    do_write(22, 7, 1, 1'b1, 1'b0);
    do_write(44, 8, 2, 1'b1, 1'b1);
    do_write(9, 9, 0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule